// File: doc/BRIEF.md
# Byte FIFO Status and Interrupt Unit

This unit sits between a register port and a serial bus engine. It holds two byte queues of 64 entries: a transmit queue filled by register writes and drained by the engine, and a receive queue filled by the engine and drained by register reads. Each queue has a programmable threshold. The unit turns queue occupancy and access errors into sticky interrupt status bits. An idle timer raises an extra event when a few received bytes have been left below the receive threshold for too long.

The status bits are cleared by a write-one-to-clear strobe. A single interrupt line is the OR of the status bits gated by an enable vector. A packed status word reports both queue levels together with their full and empty flags. Queue enables, thresholds and the idle limit come in as static configuration inputs.

Top module: `fifo_irq_unit`

## Requirements
- R1: The queue status word `fifo_stat_o` holds these fields and reads zero in every other bit. Bits 6:0 give the transmit level (0 to 64). Bit 7 is transmit full and bit 8 is transmit empty. Bits 22:16 give the receive level. Bit 23 is receive full and bit 24 is receive empty.
- R2: The status bit map of `int_stat_o` is fixed. Bit 0 is transmit almost-empty and bit 1 is receive almost-full. Bits 2 and 3 are transmit underrun and transmit overrun. Bits 4 and 5 are receive underrun and receive overrun. Bit 6 is receive idle-data and bit 9 is transaction event. Bits 7 and 8 always read zero.
- R3: Bytes leave each queue in the order they entered. The head byte is visible on `eng_tx_data_o` and `rx_rdata_o` before the pop that removes it.
- R4: A register write to a full transmit queue is dropped and sets bit 3. An engine push to a full receive queue is dropped and sets bit 5. Both take effect at the clock edge of the attempt.
- R5: An engine pop from an empty transmit queue sets bit 2. A register read from an empty receive queue sets bit 4. In both cases the data output reads 0.
- R6: Bit 0 is set at every edge where the enabled transmit level is at or below `tx_trig_i`. Bit 1 is set at every edge where the enabled receive level is at or above `rx_trig_i`.
- R7: Suppose the receive level is non-zero and below `rx_trig_i`, and no push occurs. Then bit 6 is set at the edge `trail_lim_i + 1` cycles after the last push edge. It fires once per idle period. A push restarts the timer.
- R8: A cycle with `xfer_evt_i` high sets bit 9 at that edge.
- R9: `clr_i` clears exactly the status bits set in `clr_mask_i` at the next edge. A bit that is being set in the same cycle stays set.
- R10: `irq_o` is high in the same cycle as any status bit whose enable in `int_en_i` is high. It is low otherwise.
- R11: A disabled queue is held empty. Writes, reads, pushes and pops on it are ignored and raise no status. Its threshold bit is not set.
- R12: During and right after reset, `int_stat_o` is 0 and `irq_o` is 0. Both queues report empty with a level of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit queue enable |
| rx_en_i | input | 1 | Receive queue enable |
| tx_trig_i | input | 7 | Transmit almost-empty threshold |
| rx_trig_i | input | 7 | Receive almost-full threshold |
| trail_lim_i | input | 4 | Receive idle limit in cycles (usual setting 0xF) |
| tx_wr_i | input | 1 | Register write strobe into transmit queue |
| tx_wdata_i | input | 8 | Byte written into transmit queue |
| rx_rd_i | input | 1 | Register read strobe from receive queue |
| rx_rdata_o | output | 8 | Receive queue head byte |
| eng_tx_pop_i | input | 1 | Engine pop from transmit queue |
| eng_tx_data_o | output | 8 | Transmit queue head byte |
| eng_rx_push_i | input | 1 | Engine push into receive queue |
| eng_rx_data_i | input | 8 | Byte pushed into receive queue |
| xfer_evt_i | input | 1 | Transaction event pulse from engine |
| int_en_i | input | 10 | Interrupt enable per status bit |
| clr_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | 10 | Bits to clear |
| int_stat_o | output | 10 | Sticky interrupt status |
| irq_o | output | 1 | Masked interrupt request |
| fifo_stat_o | output | 32 | Packed queue levels and flags |

## Verification
Error bits, the event bit and the clears land at the edge that samples the strobe. They are checked two time units after that edge. Threshold bits are one edge later than the level change that causes them, so the bench waits one extra cycle before it looks. The idle bit is checked both one edge before and at the edge `trail_lim_i + 1` cycles after the last push. `irq_o` is combinational and is checked in the cycle where the enable changes. Head bytes are compared at the falling edge while a pop or read strobe is held. Strobes are driven just after the rising edge, so that comparison never races the edge.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int STAT_W     = 10;
  localparam int SB_TX_AE   = 0;
  localparam int SB_RX_AF   = 1;
  localparam int SB_TX_UDF  = 2;
  localparam int SB_TX_OVF  = 3;
  localparam int SB_RX_UDF  = 4;
  localparam int SB_RX_OVF  = 5;
  localparam int SB_TRAIL   = 6;
  localparam int SB_XFER    = 9;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LVL_W-1:0] lvl_q;
  logic do_wr, do_rd;

  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign do_rd   = rd_i && !empty_o;
  assign do_wr   = wr_i && (!full_o || rd_i);
  assign ovf_o   = wr_i && full_o && !rd_i;
  assign udf_o   = rd_i && empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rp_q];
  assign level_o = lvl_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_wr && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; lvl_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; lvl_q <= '0;
    end else begin
      if (do_wr) wp_q <= nxt(wp_q);
      if (do_rd) rp_q <= nxt(rp_q);
      case ({do_wr, do_rd})
        2'b10:   lvl_q <= lvl_q + LVL_W'(1);
        2'b01:   lvl_q <= lvl_q - LVL_W'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
  parameter int CNT_W = 4,
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] trig_i,
  input  logic             push_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic fired_q, waiting;

  // residual bytes sitting below threshold
  assign waiting = en_i && (lvl_i != '0) && (lvl_i < trig_i);
  assign hit_o   = waiting && !push_i && (cnt_q >= limit_i) && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; fired_q <= 1'b0;
    end else if (!waiting || push_i) begin
      cnt_q <= '0; fired_q <= 1'b0;
    end else if (cnt_q >= limit_i) begin
      fired_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~(clr_i ? clr_mask_i : '0)) | set_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DW      = 8,
  parameter int TRAIL_W = 4,
  localparam int LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_en_i,
  input  logic               rx_en_i,
  input  logic [LVL_W-1:0]   tx_trig_i,
  input  logic [LVL_W-1:0]   rx_trig_i,
  input  logic [TRAIL_W-1:0] trail_lim_i,
  input  logic               tx_wr_i,
  input  logic [DW-1:0]      tx_wdata_i,
  input  logic               rx_rd_i,
  output logic [DW-1:0]      rx_rdata_o,
  input  logic               eng_tx_pop_i,
  output logic [DW-1:0]      eng_tx_data_o,
  input  logic               eng_rx_push_i,
  input  logic [DW-1:0]      eng_rx_data_i,
  input  logic               xfer_evt_i,
  input  logic [STAT_W-1:0]  int_en_i,
  input  logic               clr_i,
  input  logic [STAT_W-1:0]  clr_mask_i,
  output logic [STAT_W-1:0]  int_stat_o,
  output logic               irq_o,
  output logic [31:0]        fifo_stat_o
);
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, tx_ovf, tx_udf;
  logic rx_full, rx_empty, rx_ovf, rx_udf;
  logic trail_hit;
  logic [STAT_W-1:0] set_vec;

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(!tx_en_i),
    .wr_i(tx_wr_i && tx_en_i), .wdata_i(tx_wdata_i),
    .rd_i(eng_tx_pop_i && tx_en_i), .rdata_o(eng_tx_data_o),
    .level_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty),
    .ovf_o(tx_ovf), .udf_o(tx_udf)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(!rx_en_i),
    .wr_i(eng_rx_push_i && rx_en_i), .wdata_i(eng_rx_data_i),
    .rd_i(rx_rd_i && rx_en_i), .rdata_o(rx_rdata_o),
    .level_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty),
    .ovf_o(rx_ovf), .udf_o(rx_udf)
  );

  trail_timer #(.CNT_W(TRAIL_W), .LVL_W(LVL_W)) u_trail (
    .clk_i, .rst_ni, .en_i(rx_en_i), .lvl_i(rx_lvl), .trig_i(rx_trig_i),
    .push_i(eng_rx_push_i), .limit_i(trail_lim_i), .hit_o(trail_hit)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[SB_TX_AE]  = tx_en_i && (tx_lvl <= tx_trig_i);
    set_vec[SB_RX_AF]  = rx_en_i && (rx_lvl >= rx_trig_i);
    set_vec[SB_TX_UDF] = tx_udf;
    set_vec[SB_TX_OVF] = tx_ovf;
    set_vec[SB_RX_UDF] = rx_udf;
    set_vec[SB_RX_OVF] = rx_ovf;
    set_vec[SB_TRAIL]  = trail_hit;
    set_vec[SB_XFER]   = xfer_evt_i;
  end

  irq_status #(.W(STAT_W)) u_stat (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i, .clr_mask_i,
    .en_i(int_en_i), .stat_o(int_stat_o), .irq_o
  );

  // packed word layout fixed; level fields hold up to 7 bits
  always_comb begin
    fifo_stat_o            = '0;
    fifo_stat_o[LVL_W-1:0] = tx_lvl;
    fifo_stat_o[7]         = tx_full;
    fifo_stat_o[8]         = tx_empty;
    fifo_stat_o[16 +: LVL_W] = rx_lvl;
    fifo_stat_o[23]        = rx_full;
    fifo_stat_o[24]        = rx_empty;
  end
endmodule

// File: rtl/fifo_irq_unit_chk.sv
module fifo_irq_unit_chk
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DW      = 8,
  parameter int TRAIL_W = 4,
  localparam int LVL_W  = $clog2(DEPTH) + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tx_en_i,
  input logic               rx_en_i,
  input logic [LVL_W-1:0]   tx_trig_i,
  input logic [LVL_W-1:0]   rx_trig_i,
  input logic [TRAIL_W-1:0] trail_lim_i,
  input logic               tx_wr_i,
  input logic [DW-1:0]      tx_wdata_i,
  input logic               rx_rd_i,
  input logic [DW-1:0]      rx_rdata_o,
  input logic               eng_tx_pop_i,
  input logic [DW-1:0]      eng_tx_data_o,
  input logic               eng_rx_push_i,
  input logic [DW-1:0]      eng_rx_data_i,
  input logic               xfer_evt_i,
  input logic [STAT_W-1:0]  int_en_i,
  input logic               clr_i,
  input logic [STAT_W-1:0]  clr_mask_i,
  input logic [STAT_W-1:0]  int_stat_o,
  input logic               irq_o,
  input logic [31:0]        fifo_stat_o
);
  assert_tx_lvl_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_stat_o[LVL_W-1:0] <= LVL_W'(DEPTH));
  assert_rx_full_lvl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_stat_o[23] |-> (fifo_stat_o[16 +: LVL_W] == LVL_W'(DEPTH)) && !fifo_stat_o[24]);
  assert_unused_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_stat_o[8:7] == 2'b00);
  assert_tx_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && tx_wr_i && fifo_stat_o[7] && !eng_tx_pop_i) |=> int_stat_o[SB_TX_OVF]);
  assert_rx_udf_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && fifo_stat_o[24]) |-> (rx_rdata_o == '0));
  assert_xfer_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_evt_i |=> int_stat_o[SB_XFER]);
  assert_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && clr_mask_i[SB_XFER] && !xfer_evt_i) |=> !int_stat_o[SB_XFER]);
  assert_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_i == '0) |-> !irq_o);
  assert_tx_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (fifo_stat_o[LVL_W-1:0] == '0));
endmodule

bind fifo_irq_unit fifo_irq_unit_chk #(.DEPTH(DEPTH), .DW(DW), .TRAIL_W(TRAIL_W)) chk_i (.*);

// File: tb/fifo_irq_unit_tb_top.sv
module fifo_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tx_en_i = 1'b1, rx_en_i = 1'b1;
  logic [6:0] tx_trig_i = 7'd2, rx_trig_i = 7'd4;
  logic [3:0] trail_lim_i = 4'd3;
  logic tx_wr_i = 0, rx_rd_i = 0, eng_tx_pop_i = 0, eng_rx_push_i = 0, xfer_evt_i = 0, clr_i = 0;
  logic [7:0] tx_wdata_i = 0, eng_rx_data_i = 0, rx_rdata_o, eng_tx_data_o;
  logic [9:0] int_en_i = 0, clr_mask_i = 0, int_stat_o;
  logic irq_o;
  logic [31:0] fifo_stat_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] q_tx[$], q_rx[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fifo_irq_unit dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk_i); #2; endtask

  task automatic tx_write(input logic [7:0] b, input bit keep);
    if (keep) q_tx.push_back(b);
    tx_wr_i = 1; tx_wdata_i = b; cyc(); tx_wr_i = 0;
  endtask
  task automatic rx_push(input logic [7:0] b, input bit keep);
    if (keep) q_rx.push_back(b);
    eng_rx_push_i = 1; eng_rx_data_i = b; cyc(); eng_rx_push_i = 0;
  endtask
  task automatic tx_pop(); eng_tx_pop_i = 1; cyc(); eng_tx_pop_i = 0; endtask
  task automatic rx_read(); rx_rd_i = 1; cyc(); rx_rd_i = 0; endtask
  task automatic clear(input logic [9:0] m); clr_i = 1; clr_mask_i = m; cyc(); clr_i = 0; endtask

  // monitor: compare head bytes against scoreboard while a strobe is held
  always @(negedge clk_i) begin
    if (rst_ni && eng_tx_pop_i && tx_en_i) begin
      if (q_tx.size() > 0) chk("R3", "tx head", eng_tx_data_o, q_tx.pop_front());
      else chk("R5", "tx empty data", eng_tx_data_o, 0);
    end
    if (rst_ni && rx_rd_i && rx_en_i) begin
      if (q_rx.size() > 0) chk("R3", "rx head", rx_rdata_o, q_rx.pop_front());
      else chk("R5", "rx empty data", rx_rdata_o, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R12", "reset stat", int_stat_o, 0);
    chk("R12", "reset fifo word", fifo_stat_o, 32'h0100_0100);
    chk("R12", "reset irq", irq_o, 0);
    @(posedge clk_i); #2; rst_ni = 1;
    cyc();
    chk("R6", "tx almost-empty", int_stat_o[0], 1);
    chk("R10", "masked irq", irq_o, 0);
    int_en_i = 10'h001; #1;
    chk("R10", "enabled irq", irq_o, 1);
    clear(10'h3FF);
    chk("R9", "set wins over clear", int_stat_o[0], 1);
    tx_write(8'hA1, 1); tx_write(8'hA2, 1); tx_write(8'hA3, 1);
    chk("R1", "tx level 3", fifo_stat_o[8:0], 9'h003);
    clear(10'h3FF);
    chk("R9", "clear all", int_stat_o, 0);
    chk("R10", "irq after clear", irq_o, 0);
    repeat (4) tx_pop();
    chk("R5", "tx underrun bit", int_stat_o[2], 1);
    for (int i = 0; i < DEPTH; i++) tx_write(8'(i * 7 + 3), 1);
    chk("R1", "tx full word", fifo_stat_o[8:0], 9'h0C0);
    tx_write(8'hEE, 0);
    chk("R4", "tx overrun bit", int_stat_o[3], 1);
    clear(10'h004);
    chk("R9", "selective clear", int_stat_o[3:2], 2'b10);
    for (int i = 0; i < DEPTH; i++) tx_pop();
    chk("R3", "tx drained", fifo_stat_o[8:0], 9'h100);
    clear(10'h3FF);
    rx_push(8'h11, 1); rx_push(8'h22, 1);
    repeat (3) cyc();
    chk("R7", "idle bit early", int_stat_o[6], 0);
    cyc();
    chk("R7", "idle bit due", int_stat_o[6], 1);
    chk("R6", "rx below trig", int_stat_o[1], 0);
    rx_push(8'h33, 1); rx_push(8'h44, 1);
    cyc();
    chk("R6", "rx almost-full", int_stat_o[1], 1);
    repeat (5) rx_read();
    chk("R5", "rx underrun bit", int_stat_o[4], 1);
    for (int i = 0; i < DEPTH; i++) rx_push(8'(i * 5 + 1), 1);
    rx_push(8'hDD, 0);
    chk("R4", "rx overrun bit", int_stat_o[5], 1);
    chk("R1", "rx full word", fifo_stat_o[24:16], 9'h0C0);
    for (int i = 0; i < DEPTH; i++) rx_read();
    chk("R3", "rx drained", fifo_stat_o[24:16], 9'h100);
    xfer_evt_i = 1; cyc(); xfer_evt_i = 0;
    chk("R8", "event bit", int_stat_o[9], 1);
    int_en_i = 10'h200; #1;
    chk("R10", "event irq", irq_o, 1);
    int_en_i = 10'h000; #1;
    chk("R10", "event masked", irq_o, 0);
    tx_write(8'h55, 1); q_tx.delete();
    tx_en_i = 0; rx_en_i = 0; cyc();
    clear(10'h3FF);
    tx_write(8'h66, 0); rx_push(8'h77, 0); tx_pop(); rx_read(); cyc();
    chk("R11", "disabled levels", fifo_stat_o, 32'h0100_0100);
    chk("R11", "disabled no status", int_stat_o, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule